// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 64 interrupt inputs and steers each to one of eight output lines: a normal interrupt line, a fast interrupt line and six auxiliary lines. Every source owns one configuration byte. The byte enables the source, chooses how its input is read (active-high level, rising edge, falling edge, or both edges), and names its destination line. Inputs are resynchronised to the block clock before they are used. Edge events are held in status bits, and software clears them by writing ones.

Each output line has a priority register. Reading it returns the index of the source that currently wins among the eligible pending sources on that line. A read that returns a winner records that index as granted. A bit in the same register selects fixed or rotating order. The register bus is plain and word-wide: the address is a byte address that must be word-aligned, each byte lane has its own strobe, and read data is combinational from the address. No data streams cross the block's edge, so no port carries a valid/ready handshake.

Top module: `vic_top`

## Requirements
- R1: After reset, every configuration byte reads 0, which means disabled, level mode and destination 0. All output lines are low. Priority register 0 (address 0x20) reads 0x40, which is rotating order with index 0. Every other priority register (addresses 0x24 to 0x3C, destination d at 0x20+4d) reads 0.
- R2: The configuration byte of source n sits at address 0x40+n, in byte lane n%4 of its word. Bit 3 is enable, bit 5 is rising edge, bit 6 is falling edge and bits 2:0 are the destination. Bits 7 and 4 always read 0. The other bits read back as written.
- R3: A source with bits 6:5 = 00 is pending while its input, delayed through a two-flop synchroniser, is high.
- R4: A source with bit 5 set latches a status bit on a 0-to-1 input change. A source with bit 6 set latches on a 1-to-0 change. The status bit stays set after the input returns. Sources 0-31 use bit n of the word at 0x80, and sources 32-63 use bit n-32 of the word at 0x84. An edge-mode source is pending while its status bit is set.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: When a new edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Output line d (0 = irq_out, 1 = fiq_out, 2..7 = aux_out[0..5]) is high exactly when at least one enabled source with destination d is pending. A disabled source never drives a line.
- R8: In fixed order (priority register bit 6 = 0), bits 5:0 read the lowest pending eligible index.
- R9: In rotating order (bit 6 = 1), the search starts at the index just after the last granted index and wraps from 63 to 0. Reading the register while its line is high grants the returned index.
- R10: Reading a priority register while its line is low returns the last granted index and leaves that index unchanged.
- R11: A write to a priority register updates only bit 6 (when byte strobe 0 is set). Bits 5:0 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Raw interrupt inputs, asynchronous |
| bus_addr | input | 8 | Byte address, word-aligned |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_be | input | 4 | Byte lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read of a priority register grants its winner |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Destination 0 line |
| fiq_out | output | 1 | Destination 1 line |
| aux_out | output | 6 | Destinations 2 to 7 |

## Verification
Sparse random input vectors are run across a random mix of enables, destinations and order modes. Each one is compared with a reference model of the eligible set on every line and of each register's grant history. This separates masking and routing errors from arbitration errors. A directed sequence of three sources on a rotating line shows the wrap from 63 back to low indices, and a fixed-order line is read twice to show that the same winner repeats. Edge tests drive rising, falling and held inputs to tell a latched event from a level. A clear is timed to land on the very cycle of a fresh edge to show which of the two takes effect.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CTRL_W0 = 16;
  localparam int STAT_W0 = 32;
  localparam int PRIO_W0 = 8;
  localparam int EN_BIT   = 3;
  localparam int RISE_BIT = 5;
  localparam int FALL_BIT = 6;
  localparam int ROT_BIT  = 6;
  localparam logic [7:0] CTRL_KEEP = 8'h6F;
  localparam int DST_LSB = 0;
  localparam int DST_W   = 3;
endpackage

// File: rtl/vic_src_cond.sv
module vic_src_cond #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] lvl,
  output logic [N-1:0] hit,
  output logic [N-1:0] stat
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl = s2_q;
  assign hit = (s2_q & ~s3_q & rise_en) | (~s2_q & s3_q & fall_en);

  // a fresh edge outranks a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | hit;
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int N = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic             rotate,
  input  logic [IDX_W-1:0] last,
  output logic             any,
  output logic [IDX_W-1:0] win
);
  logic [N-1:0] above, upper;

  function automatic logic [IDX_W-1:0] first_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) above[i] = (i > int'(last));
    upper = req & above;
    any = |req;
    if (rotate && (|upper)) win = first_set(upper);
    else                    win = first_set(req);
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int N_DST  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out,
  output logic [N_DST-3:0]  aux_out
);
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int N_CW   = N_SRC / 4;
  localparam int N_SW   = N_SRC / 32;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic [7:0]        ctrl_q [N_SRC];
  logic [N_DST-1:0]  rot_q;
  logic [N_DST-1:0][IDX_W-1:0] last_q;

  logic [N_SRC-1:0] en_vec, rise_en, fall_en, lvl_w, stat_q, edge_hit_w, clr_w, pend;
  logic [N_SRC-1:0] req [N_DST];
  logic [N_DST-1:0] any_w;
  logic [IDX_W-1:0] win_w [N_DST];
  logic [N_CW-1:0]  wr_ctrl;
  logic [N_SW-1:0]  wr_stat;
  logic [N_DST-1:0] wr_prio, rd_prio;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_comb begin
    for (int w = 0; w < N_CW; w++)
      wr_ctrl[w] = bus_wr && aligned && (int'(word) == CTRL_W0 + w);
    for (int s = 0; s < N_SW; s++)
      wr_stat[s] = bus_wr && aligned && (int'(word) == STAT_W0 + s);
    for (int d = 0; d < N_DST; d++) begin
      wr_prio[d] = bus_wr && aligned && (int'(word) == PRIO_W0 + d);
      rd_prio[d] = bus_rd && aligned && (int'(word) == PRIO_W0 + d);
    end
  end

  always_comb begin
    for (int n = 0; n < N_SRC; n++) begin
      en_vec[n]  = ctrl_q[n][EN_BIT];
      rise_en[n] = ctrl_q[n][RISE_BIT];
      fall_en[n] = ctrl_q[n][FALL_BIT];
      pend[n]    = (rise_en[n] || fall_en[n]) ? stat_q[n] : lvl_w[n];
      clr_w[n]   = wr_stat[n / 32] && bus_be[(n % 32) / 8] && bus_wdata[n % 32];
    end
  end

  vic_src_cond #(.N(N_SRC)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (src_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .clr     (clr_w),
    .lvl     (lvl_w),
    .hit     (edge_hit_w),
    .stat    (stat_q)
  );

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    always_comb begin
      for (int n = 0; n < N_SRC; n++)
        req[d][n] = en_vec[n] && pend[n] &&
                    (ctrl_q[n][DST_LSB +: DST_W] == DST_W'(d));
    end

    vic_arb #(.N(N_SRC), .IDX_W(IDX_W)) u_arb (
      .req    (req[d]),
      .rotate (rot_q[d]),
      .last   (last_q[d]),
      .any    (any_w[d]),
      .win    (win_w[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_SRC; n++) ctrl_q[n] <= '0;
      rot_q  <= N_DST'(1);
      last_q <= '0;
    end else begin
      for (int w = 0; w < N_CW; w++) begin
        for (int l = 0; l < 4; l++) begin
          if (wr_ctrl[w] && bus_be[l]) ctrl_q[4*w + l] <= bus_wdata[8*l +: 8] & CTRL_KEEP;
        end
      end
      for (int d = 0; d < N_DST; d++) begin
        if (wr_prio[d] && bus_be[0]) rot_q[d] <= bus_wdata[ROT_BIT];
        if (rd_prio[d] && any_w[d])  last_q[d] <= win_w[d];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < N_CW; w++) begin
      if (aligned && (int'(word) == CTRL_W0 + w)) begin
        for (int l = 0; l < 4; l++) bus_rdata[8*l +: 8] = ctrl_q[4*w + l];
      end
    end
    for (int s = 0; s < N_SW; s++) begin
      if (aligned && (int'(word) == STAT_W0 + s)) bus_rdata = stat_q[32*s +: 32];
    end
    for (int d = 0; d < N_DST; d++) begin
      if (aligned && (int'(word) == PRIO_W0 + d)) begin
        bus_rdata[ROT_BIT]     = rot_q[d];
        bus_rdata[IDX_W-1:0]   = any_w[d] ? win_w[d] : last_q[d];
      end
    end
  end

  assign irq_out = any_w[0];
  assign fiq_out = any_w[1];
  assign aux_out = any_w[N_DST-1:2];
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N = 64,
  parameter int IDX_W = 6,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [N-1:0]      stat,
  input logic [N-1:0]      hit,
  input logic [N-1:0]      clr,
  input logic [N-1:0]      en_vec,
  input logic [IDX_W-1:0]  last_irq
);
  logic irq_grant;
  assign irq_grant = bus_rd && (bus_addr == ADDR_W'(32'h20)) && irq_out;

  // R4
  stat_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat) & ~$past(hit)) == '0));

  // R6
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit) & ~stat) == '0));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & $past(clr) & ~$past(hit) & stat) == '0));

  // R9
  grant_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grant |=> (last_irq == $past(bus_rdata[IDX_W-1:0])));

  // R10
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_grant |=> $stable(last_irq));

  // R7
  quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> (!irq_out && !fiq_out));
endmodule

bind vic_top vic_chk #(.N(N_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .fiq_out   (fiq_out),
  .stat      (stat_q),
  .hit       (edge_hit_w),
  .clr       (clr_w),
  .en_vec    (en_vec),
  .last_irq  (last_q[0])
);

// File: tb/vic_top_test.sv
module vic_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;
  logic [5:0]  aux_out;

  int total = 0;
  int bad = 0;
  int          mlast [8];
  bit          mrot [8];
  bit          men [64];
  int          mdst [64];
  logic [31:0] rv;

  always #4 clk = ~clk;

  vic_top uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out), .aux_out(aux_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_ctrl(input int n, input logic [7:0] v);
    wr(8'h40 + 8'(n & ~3), 4'b0001 << (n % 4), {24'h0, v} << (8 * (n % 4)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_win(input logic [63:0] r, input bit rot, input int last);
    if (rot) begin
      for (int k = 1; k <= 64; k++) if (r[(last + k) % 64]) return (last + k) % 64;
    end else begin
      for (int i = 0; i < 64; i++) if (r[i]) return i;
    end
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 lines", {30'h0, irq_out, fiq_out} | {26'h0, aux_out}, 32'h0);
    rd(8'h20, rv); chk("R1 irq prio", rv, 32'h40);
    rd(8'h24, rv); chk("R1 fiq prio", rv, 32'h0);
    rd(8'h3C, rv); chk("R1 aux prio", rv, 32'h0);
    rd(8'h5C, rv); chk("R1 ctrl", rv, 32'h0);

    // R2 layout and reserved bits
    set_ctrl(7, 8'hFF);
    rd(8'h44, rv); chk("R2 ctrl readback", rv, 32'h6F00_0000);
    set_ctrl(7, 8'h00);

    // R11 index field ignores writes
    wr(8'h20, 4'hF, 32'h3F);
    rd(8'h20, rv); chk("R11 prio write", rv, 32'h0);
    wr(8'h20, 4'hF, 32'h40);
    rd(8'h20, rv); chk("R11 rotate set", rv, 32'h40);

    // R3 level source
    set_ctrl(10, 8'h08);
    src_in[10] = 1'b1; idle(4);
    chk("R3 level high", {31'h0, irq_out}, 32'h1);
    rd(8'h20, rv); chk("R3 winner", rv, 32'h4A);
    src_in[10] = 1'b0; idle(4);
    chk("R3 level low", {31'h0, irq_out}, 32'h0);

    // R9 rotation from last grant 10 with wrap
    set_ctrl(5, 8'h08); set_ctrl(9, 8'h08); set_ctrl(60, 8'h08);
    src_in[5] = 1'b1; src_in[9] = 1'b1; src_in[60] = 1'b1; idle(4);
    rd(8'h20, rv); chk("R9 rot 1", rv, 32'h40 | 60);
    rd(8'h20, rv); chk("R9 rot 2 wrap", rv, 32'h40 | 5);
    rd(8'h20, rv); chk("R9 rot 3", rv, 32'h40 | 9);

    // R8 fixed order on fiq
    set_ctrl(5, 8'h09); set_ctrl(9, 8'h09);
    rd(8'h24, rv); chk("R8 fixed 1", rv, 32'd5);
    rd(8'h24, rv); chk("R8 fixed 2", rv, 32'd5);
    chk("R7 fiq line", {31'h0, fiq_out}, 32'h1);

    // R10 nothing pending
    src_in = '0; idle(4);
    chk("R10 idle line", {31'h0, irq_out}, 32'h0);
    rd(8'h20, rv); chk("R10 prev winner", rv, 32'h40 | 9);
    rd(8'h20, rv); chk("R10 prev kept", rv, 32'h40 | 9);

    // R7 routing to aux3 and masking
    set_ctrl(20, 8'h0D);
    src_in[20] = 1'b1; idle(4);
    chk("R7 aux route", {26'h0, aux_out}, 32'h08);
    chk("R7 irq clear", {31'h0, irq_out}, 32'h0);
    set_ctrl(20, 8'h05); idle(1);
    chk("R7 disabled", {26'h0, aux_out}, 32'h0);
    src_in[20] = 1'b0;

    // R4 rising edge latch on source 40 and source 3
    set_ctrl(40, 8'h28); set_ctrl(3, 8'h28);
    src_in[40] = 1'b1; src_in[3] = 1'b1; idle(4);
    src_in[40] = 1'b0; src_in[3] = 1'b0; idle(4);
    rd(8'h84, rv); chk("R4 hi word", rv, 32'h100);
    rd(8'h80, rv); chk("R4 lo word", rv, 32'h8);
    chk("R4 edge pending", {31'h0, irq_out}, 32'h1);

    // R5 write-zero no effect, write-one clears
    wr(8'h84, 4'hF, 32'h0);
    rd(8'h84, rv); chk("R5 zero write", rv, 32'h100);
    wr(8'h84, 4'hF, 32'h100); wr(8'h80, 4'hF, 32'h8);
    rd(8'h84, rv); chk("R5 cleared", rv, 32'h0);
    chk("R5 line low", {31'h0, irq_out}, 32'h0);

    // R4 falling edge on source 33
    set_ctrl(33, 8'h48);
    src_in[33] = 1'b1; idle(4);
    rd(8'h84, rv); chk("R4 no fall yet", rv, 32'h0);
    src_in[33] = 1'b0; idle(4);
    rd(8'h84, rv); chk("R4 fall latched", rv, 32'h2);
    wr(8'h84, 4'hF, 32'h2);

    // R6 edge and clear in the same cycle
    src_in[40] = 1'b1;
    idle(2);
    wr(8'h84, 4'hF, 32'h100);
    rd(8'h84, rv); chk("R6 edge wins", rv, 32'h100);
    src_in = '0;
    wr(8'h80, 4'hF, 32'hFFFF_FFFF); wr(8'h84, 4'hF, 32'hFFFF_FFFF);

    // model state for random phase
    for (int d = 0; d < 8; d++) begin
      mrot[d] = 1'($urandom % 2);
      wr(8'h20 + 8'(4 * d), 4'h1, {25'h0, mrot[d], 6'h0});
    end
    rd(8'h20, rv); mlast[0] = 9;
    rd(8'h24, rv); mlast[1] = 5;
    for (int d = 2; d < 8; d++) mlast[d] = 0;
    for (int w = 0; w < 16; w++) begin
      logic [31:0] dat;
      for (int l = 0; l < 4; l++) begin
        men[4*w+l]  = 1'($urandom % 2);
        mdst[4*w+l] = int'($urandom % 8);
        dat[8*l +: 8] = {4'h0, men[4*w+l], 3'(mdst[4*w+l])};
      end
      wr(8'h40 + 8'(4 * w), 4'hF, dat);
    end

    // R7 R8 R9 random level patterns
    for (int it = 0; it < 40; it++) begin
      logic [63:0] s;
      logic [7:0]  lines;
      s = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      src_in = s; idle(4);
      for (int d = 0; d < 8; d++) begin
        logic [63:0] r;
        int ew;
        for (int n = 0; n < 64; n++) r[n] = s[n] && men[n] && (mdst[n] == d);
        lines = {aux_out, fiq_out, irq_out};
        chk("R7 random line", {31'h0, lines[d]}, {31'h0, |r});
        rd(8'h20 + 8'(4 * d), rv);
        ew = (|r) ? exp_win(r, mrot[d], mlast[d]) : mlast[d];
        if (|r) mlast[d] = ew;
        chk(mrot[d] ? "R9 random winner" : "R8 random winner", rv, {25'h0, mrot[d], 6'(ew)});
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule